// File: doc/BRIEF.md
# Prioritised 32-Line Interrupt Controller

This block collects up to 32 external interrupt request lines and tells the processor which one to take next. Each line has an enable bit, a pending bit and a two-bit priority level. Software reaches this state through a small register bus. Enables and pending bits are changed through separate set and clear registers, so one write never disturbs another line. Priorities are packed four to a 32-bit word.

A rising edge on a request input makes that line pending. The consumer clears it by presenting the line number on an acknowledge port. A combinational arbiter looks only at lines that are both enabled and pending. It reports the exception number of the winner, which is the line number plus 16, or zero when no line qualifies. A separate flag reports whether any line is pending, whether or not that line is enabled.

Top module: `irqc_top`

## Requirements
- R1: After reset, every enable bit, pending bit and priority field is zero, `pend_vector` is 0 and `any_pending` is 0.
- R2: A write to offset 0x100 sets the enable bit of every line whose data bit is 1. Data bits at 0 leave their lines unchanged. Reads of 0x100 and of 0x180 both return the enable bits, with line n at bit n.
- R3: A write to offset 0x180 clears the enable bit of every line whose data bit is 1. Data bits at 0 have no effect.
- R4: A write to 0x200 sets, and a write to 0x280 clears, the pending bit of each line whose data bit is 1. Data bits at 0 have no effect. Reads of 0x200 and of 0x280 return the pending bits, with line n at bit n.
- R5: Word k at offset 0x400+4k (k = 0..7) holds the priority of lines 4k+j (j = 0..3) in bits [8j+7:8j+6]. All other bits of the word read as 0 and ignore writes, and offsets outside the mapped registers read as 0.
- R6: A 0-to-1 transition on `irq_in[n]`, seen at a clock edge, sets pending bit n at that edge. A level held high does not set the bit again after it has been cleared.
- R7: With `ack_valid` high at a clock edge, the pending bit of line `ack_line` is cleared at that edge.
- R8: If a rising request edge and a software clear or an acknowledge hit the same line at the same edge, the pending bit ends up set.
- R9: `pend_vector` equals n+16 for the enabled pending line n with the numerically smallest priority value. Among lines at equal priority, the lowest n wins. The output is 0 when no line is both enabled and pending.
- R10: `any_pending` is 1 exactly when at least one pending bit is set, regardless of enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 12 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_in | input | 32 | Request lines, rising-edge sensitive |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_line | input | 5 | Line whose pending bit the acknowledge clears |
| pend_vector | output | 9 | Exception number of the winning request, 0 if none |
| any_pending | output | 1 | At least one line is pending |

## Verification
The hardest situation to reach is a collision at a single clock edge: a request edge arriving on a line in the same cycle that software clears that line, or that an acknowledge names it. The stimulus reaches it by raising the request input on the same falling clock edge that drives the clear write or the acknowledge. The sampled result then shows which of the two won. The arbitration tie-break is exercised by a sweep of pseudo-random priority, enable and pending patterns, in which equal priorities occur often. Directed cases also place every line in turn against the highest line at equal priority.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ADDR_W      = 12;
  localparam int EXC_OFFSET  = 16;
  localparam logic [ADDR_W-1:0] ADDR_SET_EN    = 12'h100;
  localparam logic [ADDR_W-1:0] ADDR_CLR_EN    = 12'h180;
  localparam logic [ADDR_W-1:0] ADDR_SET_PEND  = 12'h200;
  localparam logic [ADDR_W-1:0] ADDR_CLR_PEND  = 12'h280;
  localparam logic [ADDR_W-1:0] ADDR_PRIO_BASE = 12'h400;

  // lowest bit of the priority field for slot j: the field sits at the top of byte j
  function automatic int prio_lsb(input int slot, input int pw);
    return 8 * slot + 8 - pw;
  endfunction

  // exception number reported for a line
  function automatic int exc_number(input int line);
    return line + EXC_OFFSET;
  endfunction
endpackage

// File: rtl/irqc_line.sv
module irqc_line (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_in,
  input  logic sw_set_en,
  input  logic sw_clr_en,
  input  logic sw_set_pend,
  input  logic sw_clr_pend,
  input  logic ack_clr,
  output logic enable_q,
  output logic pending_q
);
  logic irq_q;
  logic rise;

  assign rise = irq_in & ~irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q     <= 1'b0;
      enable_q  <= 1'b0;
      pending_q <= 1'b0;
    end else begin
      irq_q <= irq_in;
      if (sw_set_en)      enable_q <= 1'b1;
      else if (sw_clr_en) enable_q <= 1'b0;
      if (rise || sw_set_pend)         pending_q <= 1'b1;
      else if (sw_clr_pend || ack_clr) pending_q <= 1'b0;
    end
  end

  assert_set_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_set_en |=> enable_q);
  assert_clr_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr_en && !sw_set_en) |=> !enable_q);
  assert_clr_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr_pend && !sw_set_pend && !rise) |=> !pending_q);
  assert_edge_pends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> pending_q);
  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_clr && !rise && !sw_set_pend) |=> !pending_q);
  assert_edge_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && (sw_clr_pend || ack_clr)) |=> pending_q);
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int NUM_LINES = 32,
  parameter int PRIO_W    = 2,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_LINES-1:0]        qualified,
  input  logic [NUM_LINES*PRIO_W-1:0] prio_flat,
  output logic                        found,
  output logic [LINE_W-1:0]           win_line
);
  logic [PRIO_W-1:0] best;

  // ascending scan with strict compare: equal levels keep the lower line
  always_comb begin
    found    = 1'b0;
    win_line = '0;
    best     = '1;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (qualified[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] < best)) begin
        found    = 1'b1;
        win_line = LINE_W'(i);
        best     = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end

  assert_idle_none_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (qualified == '0) |-> !found);
  assert_winner_qualified_R9: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> qualified[win_line]);
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int PRIO_W    = 2,
  parameter int VEC_W     = 9,
  localparam int LINE_W     = $clog2(NUM_LINES),
  localparam int PRIO_WORDS = (NUM_LINES + 3) / 4,
  localparam int IDX_W      = (PRIO_WORDS > 1) ? $clog2(PRIO_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [11:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       irq_in,
  input  logic              ack_valid,
  input  logic [4:0]        ack_line,
  output logic [VEC_W-1:0]  pend_vector,
  output logic              any_pending
);
  localparam logic [11:0] PRIO_END = ADDR_PRIO_BASE + 12'(4 * PRIO_WORDS);

  logic                        hit_set_en, hit_clr_en, hit_set_pend, hit_clr_pend;
  logic                        hit_prio;
  logic [IDX_W-1:0]            prio_idx;
  logic [NUM_LINES-1:0]        en_vec, pend_vec, qualified;
  logic [NUM_LINES*PRIO_W-1:0] prio_flat;
  logic                        arb_found;
  logic [LINE_W-1:0]           arb_line;

  assign hit_set_en   = (bus_addr == ADDR_SET_EN);
  assign hit_clr_en   = (bus_addr == ADDR_CLR_EN);
  assign hit_set_pend = (bus_addr == ADDR_SET_PEND);
  assign hit_clr_pend = (bus_addr == ADDR_CLR_PEND);
  assign hit_prio     = (bus_addr >= ADDR_PRIO_BASE) && (bus_addr < PRIO_END)
                        && (bus_addr[1:0] == 2'b00);
  assign prio_idx     = bus_addr[2 +: IDX_W];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam int WORD = i / 4;
    localparam int LSB  = prio_lsb(i % 4, PRIO_W);
    logic [PRIO_W-1:0] prio_q;

    irqc_line u_line (
      .clk         (clk),
      .rst_n       (rst_n),
      .irq_in      (irq_in[i]),
      .sw_set_en   (bus_wr && hit_set_en   && bus_wdata[i]),
      .sw_clr_en   (bus_wr && hit_clr_en   && bus_wdata[i]),
      .sw_set_pend (bus_wr && hit_set_pend && bus_wdata[i]),
      .sw_clr_pend (bus_wr && hit_clr_pend && bus_wdata[i]),
      .ack_clr     (ack_valid && (ack_line == 5'(i))),
      .enable_q    (en_vec[i]),
      .pending_q   (pend_vec[i])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        prio_q <= '0;
      else if (bus_wr && hit_prio && (prio_idx == IDX_W'(WORD)))
        prio_q <= bus_wdata[LSB +: PRIO_W];
    end

    assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q;
  end

  assign qualified = en_vec & pend_vec;

  irqc_arbiter #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .qualified (qualified),
    .prio_flat (prio_flat),
    .found     (arb_found),
    .win_line  (arb_line)
  );

  assign pend_vector = arb_found ? VEC_W'(exc_number(int'(arb_line))) : '0;
  assign any_pending = |pend_vec;

  always_comb begin
    bus_rdata = '0;
    if (hit_set_en || hit_clr_en)
      bus_rdata[NUM_LINES-1:0] = en_vec;
    else if (hit_set_pend || hit_clr_pend)
      bus_rdata[NUM_LINES-1:0] = pend_vec;
    else if (hit_prio) begin
      for (int s = 0; s < 4; s++) begin
        if (int'(prio_idx) * 4 + s < NUM_LINES)
          bus_rdata[prio_lsb(s, PRIO_W) +: PRIO_W] =
            prio_flat[(int'(prio_idx) * 4 + s) * PRIO_W +: PRIO_W];
      end
    end
  end

  assert_vector_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vector == '0) || ((pend_vector >= VEC_W'(EXC_OFFSET))
      && (pend_vector < VEC_W'(EXC_OFFSET + NUM_LINES))));
  assert_vector_needs_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vector != '0) |-> any_pending);
endmodule

// File: tb/irqc_top_test.sv
module irqc_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_in = '0;
  logic        ack_valid = 1'b0;
  logic [4:0]  ack_line = '0;
  logic [8:0]  pend_vector;
  logic        any_pending;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] en_m = '0;
  logic [31:0] pend_m = '0;
  logic [1:0]  prio_m [32];
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqc_top uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .ack_valid(ack_valid), .ack_line(ack_line),
    .pend_vector(pend_vector), .any_pending(any_pending)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // expected winner: scan levels from most urgent, lines upward inside a level
  function automatic logic [31:0] exp_vec();
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < 32; i++)
        if (en_m[i] && pend_m[i] && prio_m[i] == 2'(p)) return 32'(i + 16);
    return 32'd0;
  endfunction

  task automatic model_write(input logic [11:0] a, input logic [31:0] d);
    case (a)
      12'h100: en_m = en_m | d;
      12'h180: en_m = en_m & ~d;
      12'h200: pend_m = pend_m | d;
      12'h280: pend_m = pend_m & ~d;
      default:
        if (a >= 12'h400 && a < 12'h420 && a[1:0] == 2'b00)
          for (int s = 0; s < 4; s++)
            prio_m[int'(a[4:2]) * 4 + s] = d[8*s+6 +: 2];
    endcase
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic do_read(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic check_outputs(input string req);
    check({req, " vector"}, 32'(pend_vector), exp_vec());
    check({req, " any"}, 32'(any_pending), 32'(pend_m != 0));
  endtask

  initial begin
    logic [31:0] rd;
    for (int i = 0; i < 32; i++) prio_m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    foreach (rd[i]) ; // no-op to keep rd referenced
    do_read(12'h100, rd); check("R1 enable", rd, 0);
    do_read(12'h180, rd); check("R1 enable alias", rd, 0);
    do_read(12'h200, rd); check("R1 pending", rd, 0);
    do_read(12'h280, rd); check("R1 pending alias", rd, 0);
    for (int w = 0; w < 8; w++) begin
      do_read(12'h400 + 12'(4*w), rd); check("R1 priority", rd, 0);
    end
    check("R1 vector", 32'(pend_vector), 0);
    check("R1 any", 32'(any_pending), 0);

    // R2: set-enable, one line at a time, zero writes ignored
    for (int i = 0; i < 32; i++) begin
      do_write(12'h100, 32'(1) << i);
      do_write(12'h100, 32'h0);
      do_read(12'h100, rd); check("R2 set-enable", rd, en_m);
    end
    do_read(12'h180, rd); check("R2 read via clear address", rd, 32'hFFFF_FFFF);

    // R3: clear-enable
    do_write(12'h180, 32'h5555_5555);
    do_read(12'h100, rd); check("R3 clear-enable", rd, 32'hAAAA_AAAA);
    do_write(12'h180, 32'h0);
    do_read(12'h180, rd); check("R3 zero write", rd, 32'hAAAA_AAAA);

    // R4: set/clear pending, R10 any_pending
    do_write(12'h200, 32'h0000_F00F);
    do_read(12'h200, rd); check("R4 set-pending", rd, 32'h0000_F00F);
    do_write(12'h280, 32'h0000_000F);
    do_read(12'h280, rd); check("R4 clear-pending", rd, 32'h0000_F000);
    do_write(12'h200, 32'h0);
    do_read(12'h200, rd); check("R4 zero write", rd, 32'h0000_F000);
    check_outputs("R10 R9 partial enables");
    do_write(12'h280, 32'hFFFF_FFFF);
    check("R10 none pending", 32'(any_pending), 0);

    // R5: priority field layout
    for (int w = 0; w < 8; w++) begin
      do_write(12'h400 + 12'(4*w), 32'hFFFF_FFFF);
      do_read(12'h400 + 12'(4*w), rd); check("R5 reserved bits", rd, 32'hC0C0_C0C0);
      do_write(12'h400 + 12'(4*w), 32'h3F7F_BF00 ^ 32'(w));
      do_read(12'h400 + 12'(4*w), rd);
      check("R5 field placement", rd, (32'h3F7F_BF00 ^ 32'(w)) & 32'hC0C0_C0C0);
    end
    do_read(12'h420, rd); check("R5 unmapped offset", rd, 0);
    do_read(12'h402, rd); check("R5 unaligned offset", rd, 0);

    // R10: pending but disabled gives no vector
    do_write(12'h180, 32'hFFFF_FFFF);
    do_write(12'h200, 32'h0001_0000);
    check("R10 disabled pending vector", 32'(pend_vector), 0);
    check("R10 disabled pending any", 32'(any_pending), 1);

    // R9: tie-break, every line against line 31 at equal level
    do_write(12'h100, 32'hFFFF_FFFF);
    for (int w = 0; w < 8; w++) do_write(12'h400 + 12'(4*w), 32'h4040_4040);
    for (int i = 0; i < 31; i++) begin
      do_write(12'h280, 32'hFFFF_FFFF);
      do_write(12'h200, (32'(1) << i) | 32'h8000_0000);
      check("R9 tie lowest line", 32'(pend_vector), 32'(i + 16));
    end

    // R9: sweep of pseudo-random configurations
    for (int k = 0; k < 200; k++) begin
      logic [31:0] p;
      for (int w = 0; w < 8; w++) do_write(12'h400 + 12'(4*w), next_rand());
      p = next_rand();
      do_write(12'h100, p);
      do_write(12'h180, ~p | next_rand());
      p = next_rand() & next_rand();
      do_write(12'h200, p);
      do_write(12'h280, ~p);
      check_outputs("R9 sweep");
    end

    // R6: request edge sets pending
    do_write(12'h280, 32'hFFFF_FFFF);
    do_write(12'h100, 32'hFFFF_FFFF);
    for (int w = 0; w < 8; w++) do_write(12'h400 + 12'(4*w), 32'h0);
    @(negedge clk); irq_in[5] = 1'b1;
    @(negedge clk); pend_m[5] = 1'b1;
    do_read(12'h200, rd); check("R6 edge pends", rd, 32'h20);
    check("R6 vector", 32'(pend_vector), 21);
    do_write(12'h280, 32'h20);
    repeat (3) @(negedge clk);
    do_read(12'h200, rd); check("R6 held level no repend", rd, 0);
    irq_in[5] = 1'b0;
    @(negedge clk); irq_in[5] = 1'b1;
    @(negedge clk); pend_m[5] = 1'b1;
    do_read(12'h200, rd); check("R6 second edge", rd, 32'h20);

    // R7: acknowledge clears the named line only
    do_write(12'h200, 32'h0000_0300);
    @(negedge clk); ack_valid = 1'b1; ack_line = 5'd8;
    @(negedge clk); ack_valid = 1'b0; pend_m[8] = 1'b0;
    do_read(12'h200, rd); check("R7 ack clears", rd, 32'h0000_0220);
    check_outputs("R7 after ack");

    // R8: edge against software clear in the same cycle
    @(negedge clk);
    irq_in[7] = 1'b1; bus_wr = 1'b1; bus_addr = 12'h280; bus_wdata = 32'h80;
    @(negedge clk);
    bus_wr = 1'b0; pend_m[7] = 1'b1;
    do_read(12'h200, rd); check("R8 edge beats clear", rd, 32'h0000_02A0);
    // R8: edge against acknowledge in the same cycle
    @(negedge clk);
    irq_in[12] = 1'b1; ack_valid = 1'b1; ack_line = 5'd12;
    @(negedge clk);
    ack_valid = 1'b0; pend_m[12] = 1'b1;
    do_read(12'h200, rd); check("R8 edge beats ack", rd, 32'h0000_12A0);
    check_outputs("R8 outputs");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule